// File: doc/BRIEF.md
# Parallel-Port Peripheral Register Interface

This block is the peripheral end of an extended-capability parallel link. The host shares one 8-bit byte lane between command bytes and data bytes. A separate type line tells the two apart. A command byte with its top bit set names a 7-bit channel. A command byte with its top bit clear is a run-length count; this block accepts it and discards it. Each data byte that follows goes to the function that the latched channel selects.

Three functions are mapped:
- a 16-bit word output, loaded low byte first, then marked by a chip-select pulse;
- an 8-bit direction register;
- an 8-bit I/O output latch whose pins drive only where the direction register allows.

In reverse (peripheral-to-host) mode, the block drives the sampled I/O pins onto the byte lane. It does this only while the host requests reverse transfers and the I/O channel is selected.

Flow control on both directions is a four-phase handshake, and the block never drops a byte.
- Forward: `periph_busy` is the back-pressure signal. The host must not change the byte or the type line while its strobe is low. It must not start a new strobe until busy has returned low.
- Reverse: the host paces the block through `host_rev_ack`. A byte counts as delivered only after ack has risen and fallen again.

Top module: `ecp_regif`

## Requirements
- R1: `host_is_data` sampled high with a strobe marks a data byte; sampled low marks a command byte. Only command bytes change the channel.
- R2: A command byte with bit 7 = 1 loads bits 6:0 into the channel. A command byte with bit 7 = 0 (run length) leaves the channel and all outputs unchanged.
- R3: After `host_strobe_n` falls, `periph_busy` rises and the byte is taken exactly once. Busy falls only after the strobe has returned high.
- R4: Data bytes at channel 0x10 fill `word_out`: the first byte goes to bits 7:0 and the second to bits 15:8.
- R5: After each second byte, `word_cs` goes high for exactly 2 clocks, starting one clock after bits 15:8 change. `word_out` is stable while `word_cs` is high. No pulse follows a first byte.
- R6: Any channel-address command restarts the word byte order, so the next byte at 0x10 is a low byte.
- R7: A data byte at channel 0x20 loads the direction register. `io_oe[i]` = 1 makes pin i an output; 0 makes it an input.
- R8: A data byte at channel 0x21 loads the I/O latch onto `io_out`.
- R9: While `host_rev_req` is high and the channel is 0x21, `bus_oe` goes high and `bus_out` carries `io_pin_in` as sampled. `rev_clk_n` then goes low to mark the byte valid.
- R10: `rev_clk_n` returns high after `host_rev_ack` rises. Once ack falls, the pins are sampled again for the next byte.
- R11: `bus_oe` is low unless a reverse request is active at channel 0x21. It drops after the request is withdrawn.
- R12: After reset the channel is 0, `bus_oe` = 0, `io_oe` = 0, `io_out` = 0, `word_out` = 0 and `word_cs` = 0.
- R13: Data bytes at an unmapped channel (including 0 after reset) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_strobe_n | input | 1 | Host forward strobe, active low |
| host_is_data | input | 1 | Byte type: 1 data, 0 command |
| host_rev_req | input | 1 | Host requests reverse transfers |
| host_rev_ack | input | 1 | Host acknowledge of a reverse byte |
| bus_in | input | 8 | Byte lane as driven by the host |
| bus_out | output | 8 | Byte lane value driven by the block |
| bus_oe | output | 1 | Registered enable of the lane drivers |
| periph_busy | output | 1 | Forward acknowledge / back-pressure |
| rev_clk_n | output | 1 | Low while a reverse byte is valid |
| word_out | output | 16 | Word function pins |
| word_cs | output | 1 | Word chip-select pulse |
| io_pin_in | input | 8 | I/O port pin levels |
| io_out | output | 8 | I/O output latch |
| io_oe | output | 8 | Per-pin output enable (direction) |

## Verification
The assertions check the following on every cycle:
- the channel update rules for address and run-length commands;
- that busy is released only behind a high strobe;
- the exact two-clock width of the chip-select and a word held steady beneath it;
- that the lane drivers are on only at the I/O channel, and that reverse valid never appears without them.

The randomized scenarios check what a property cannot:
- that byte order and its restart after an address command hold across mixed traffic;
- that each second byte yields exactly one pulse and each first byte none;
- that register contents survive unmapped and run-length traffic;
- that successive reverse bytes carry fresh pin samples.

// File: rtl/ecp_regif_pkg.sv
package ecp_regif_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    REV_IDLE,
    REV_SETUP,
    REV_WAIT_ACK,
    REV_WAIT_REL
  } rev_state_e;

  typedef struct packed {
    logic              is_data;
    logic [DATA_W-1:0] value;
  } fwd_beat_t;
endpackage

// File: rtl/ecp_fwd_rx.sv
module ecp_fwd_rx
  import ecp_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              is_data,
  input  logic [DATA_W-1:0] bus_in,
  output logic              busy,
  output logic              beat_valid,
  output fwd_beat_t         beat
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   stb_prev;
  logic                   stb_s;
  logic                   fall;

  assign stb_s = sync_q[SYNC_STAGES-1];
  assign fall  = stb_prev & ~stb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '1;
      stb_prev   <= 1'b1;
      busy       <= 1'b0;
      beat_valid <= 1'b0;
      beat       <= '0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], strobe_n};
      stb_prev   <= stb_s;
      beat_valid <= fall;
      if (fall) begin
        beat.is_data <= is_data;
        beat.value   <= bus_in;
        busy         <= 1'b1;
      end else if (stb_s) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecp_word_out.sv
module ecp_word_out
  import ecp_regif_pkg::*;
#(
  parameter int CS_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              restart,
  input  logic [DATA_W-1:0] value,
  output logic [2*DATA_W-1:0] word,
  output logic              cs
);
  localparam int CW = $clog2(CS_CLKS + 1);

  logic          high_next;
  logic          pend;
  logic [CW-1:0] cs_cnt;

  assign cs = (cs_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_next <= 1'b0;
      pend      <= 1'b0;
      cs_cnt    <= '0;
      word      <= '0;
    end else begin
      if (pend) begin
        pend   <= 1'b0;
        cs_cnt <= CW'(CS_CLKS);
      end else if (cs_cnt != '0) begin
        cs_cnt <= cs_cnt - 1'b1;
      end

      if (restart) begin
        high_next <= 1'b0;
      end else if (wr) begin
        if (high_next) begin
          word[2*DATA_W-1:DATA_W] <= value;
          high_next               <= 1'b0;
          pend                    <= 1'b1;
        end else begin
          word[DATA_W-1:0] <= value;
          high_next        <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ecp_rev_tx.sv
module ecp_rev_tx
  import ecp_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              ack,
  input  logic              chan_ok,
  input  logic [DATA_W-1:0] pins,
  output logic [DATA_W-1:0] dout,
  output logic              oe,
  output logic              rclk_n
);
  logic [SYNC_STAGES-1:0] req_q;
  logic [SYNC_STAGES-1:0] ack_q;
  logic                   en;
  logic                   ack_s;
  rev_state_e             st;

  assign en    = req_q[SYNC_STAGES-1] & chan_ok;
  assign ack_s = ack_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      ack_q  <= '0;
      st     <= REV_IDLE;
      oe     <= 1'b0;
      rclk_n <= 1'b1;
      dout   <= '0;
    end else begin
      req_q <= {req_q[SYNC_STAGES-2:0], req};
      ack_q <= {ack_q[SYNC_STAGES-2:0], ack};
      if (!en) begin
        st     <= REV_IDLE;
        oe     <= 1'b0;
        rclk_n <= 1'b1;
      end else begin
        unique case (st)
          REV_IDLE: begin
            oe   <= 1'b1;
            dout <= pins;
            st   <= REV_SETUP;
          end
          REV_SETUP: begin
            rclk_n <= 1'b0;
            st     <= REV_WAIT_ACK;
          end
          REV_WAIT_ACK: if (ack_s) begin
            rclk_n <= 1'b1;
            st     <= REV_WAIT_REL;
          end
          REV_WAIT_REL: if (!ack_s) begin
            dout <= pins;
            st   <= REV_SETUP;
          end
          default: st <= REV_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ecp_regif.sv
module ecp_regif
  import ecp_regif_pkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter logic [6:0] A_WORD      = 7'h10,
  parameter logic [6:0] A_DIR       = 7'h20,
  parameter logic [6:0] A_IO        = 7'h21,
  parameter int         CS_CLKS     = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_strobe_n,
  input  logic          host_is_data,
  input  logic          host_rev_req,
  input  logic          host_rev_ack,
  input  logic [7:0]    bus_in,
  output logic [7:0]    bus_out,
  output logic          bus_oe,
  output logic          periph_busy,
  output logic          rev_clk_n,
  output logic [15:0]   word_out,
  output logic          word_cs,
  input  logic [7:0]    io_pin_in,
  output logic [7:0]    io_out,
  output logic [7:0]    io_oe
);
  localparam int FMT_BIT = DATA_W - 1;

  logic              fwd_valid;
  fwd_beat_t         fwd_beat;
  logic [ADDR_W-1:0] chan_addr;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] io_q;
  logic              is_addr_cmd;
  logic              data_wr;

  assign is_addr_cmd = fwd_valid & ~fwd_beat.is_data & fwd_beat.value[FMT_BIT];
  assign data_wr     = fwd_valid & fwd_beat.is_data;

  ecp_fwd_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_n  (host_strobe_n),
    .is_data   (host_is_data),
    .bus_in    (bus_in),
    .busy      (periph_busy),
    .beat_valid(fwd_valid),
    .beat      (fwd_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_addr <= '0;
      dir_q     <= '0;
      io_q      <= '0;
    end else begin
      if (is_addr_cmd) chan_addr <= fwd_beat.value[ADDR_W-1:0];
      if (data_wr && chan_addr == A_DIR) dir_q <= fwd_beat.value;
      if (data_wr && chan_addr == A_IO)  io_q  <= fwd_beat.value;
    end
  end

  ecp_word_out #(.CS_CLKS(CS_CLKS)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (data_wr && chan_addr == A_WORD),
    .restart(is_addr_cmd),
    .value  (fwd_beat.value),
    .word   (word_out),
    .cs     (word_cs)
  );

  ecp_rev_tx #(.SYNC_STAGES(SYNC_STAGES)) u_rev (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (host_rev_req),
    .ack    (host_rev_ack),
    .chan_ok(chan_addr == A_IO),
    .pins   (io_pin_in),
    .dout   (bus_out),
    .oe     (bus_oe),
    .rclk_n (rev_clk_n)
  );

  assign io_out = io_q;
  assign io_oe  = dir_q;
endmodule

// File: rtl/ecp_regif_chk.sv
module ecp_regif_chk #(
  parameter logic [6:0] A_IO = 7'h21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_strobe_n,
  input logic        periph_busy,
  input logic        word_cs,
  input logic [15:0] word_out,
  input logic        bus_oe,
  input logic        rev_clk_n,
  input logic [6:0]  chan_addr,
  input logic        beat_valid,
  input logic        beat_is_data,
  input logic [7:0]  beat_value
);
  p_rle_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_is_data && !beat_value[7] |=> $stable(chan_addr));

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_is_data && beat_value[7] |=> chan_addr == $past(beat_value[6:0]));

  p_data_keeps_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_is_data |=> $stable(chan_addr));

  p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(periph_busy) |-> $past(host_strobe_n));

  p_cs_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_cs) |=> word_cs);

  p_cs_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_cs && $past(word_cs) |=> !word_cs);

  p_cs_word_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    word_cs |-> $stable(word_out));

  p_oe_io_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(chan_addr) == A_IO);

  p_rclk_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_clk_n |-> bus_oe);
endmodule

bind ecp_regif ecp_regif_chk #(.A_IO(A_IO)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_strobe_n(host_strobe_n),
  .periph_busy  (periph_busy),
  .word_cs      (word_cs),
  .word_out     (word_out),
  .bus_oe       (bus_oe),
  .rev_clk_n    (rev_clk_n),
  .chan_addr    (chan_addr),
  .beat_valid   (fwd_valid),
  .beat_is_data (fwd_beat.is_data),
  .beat_value   (fwd_beat.value)
);

// File: tb/sim_ecp_regif.sv
`timescale 1ns/1ps
module sim_ecp_regif;
  localparam logic [6:0] A_WORD = 7'h10, A_DIR = 7'h20, A_IO = 7'h21;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_strobe_n = 1'b1, host_is_data = 1'b0, host_rev_req = 1'b0, host_rev_ack = 1'b0;
  logic [7:0] bus_in = '0, io_pin_in = '0;
  logic [7:0] bus_out, io_out, io_oe;
  logic bus_oe, periph_busy, rev_clk_n, word_cs;
  logic [15:0] word_out;

  int n_cmp = 0, n_bad = 0;
  int cs_run = 0, cs_last = 0, cs_pulses = 0;
  logic [15:0] cs_word = '0;

  logic [6:0]  m_addr = '0;
  logic [7:0]  m_dir = '0, m_io = '0;
  logic [15:0] m_word = '0;
  logic        m_high = 1'b0;
  int          m_pulses = 0;

  always #10 clk = ~clk;

  ecp_regif u0 (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (word_cs) begin
      if (cs_run == 0) cs_word = word_out;
      cs_run++;
    end else if (cs_run > 0) begin
      cs_last = cs_run;
      cs_pulses++;
      cs_run = 0;
    end
  end

  function automatic logic [6:0] next_addr(logic [6:0] a, logic is_data, logic [7:0] v);
    return (!is_data && v[7]) ? v[6:0] : a;
  endfunction

  task automatic model_apply(logic is_data, logic [7:0] v);
    if (!is_data) begin
      if (v[7]) m_high = 1'b0;
      m_addr = next_addr(m_addr, is_data, v);
    end else if (m_addr == A_DIR) m_dir = v;
    else if (m_addr == A_IO) m_io = v;
    else if (m_addr == A_WORD) begin
      if (m_high) begin m_word[15:8] = v; m_pulses++; end
      else m_word[7:0] = v;
      m_high = ~m_high;
    end
  endtask

  task automatic send(logic is_data, logic [7:0] v);
    bit seen;
    @(negedge clk);
    host_is_data = is_data; bus_in = v; host_strobe_n = 1'b0;
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = periph_busy;
    end
    check("R3 busy rises", {15'd0, seen}, 16'd1);
    repeat (3) @(negedge clk);
    check("R3 busy held while strobe low", {15'd0, periph_busy}, 16'd1);
    host_strobe_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = !periph_busy;
    end
    check("R3 busy released", {15'd0, seen}, 16'd1);
    model_apply(is_data, v);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_outputs(string tag);
    check({"R4 word ", tag}, word_out, m_word);
    check({"R5 pulse count ", tag}, 16'(cs_pulses), 16'(m_pulses));
    check({"R7 direction ", tag}, {8'd0, io_oe}, {8'd0, m_dir});
    check({"R8 io latch ", tag}, {8'd0, io_out}, {8'd0, m_io});
  endtask

  task automatic rev_read(int nbytes);
    bit ok;
    host_rev_req = 1'b1;
    for (int b = 0; b < nbytes; b++) begin
      ok = 0;
      for (int i = 0; i < 30 && !ok; i++) begin
        @(negedge clk);
        ok = !rev_clk_n;
      end
      check("R9 valid strobe low", {15'd0, ok}, 16'd1);
      check("R9 lane driven", {15'd0, bus_oe}, 16'd1);
      check("R9 sampled pins", {8'd0, bus_out}, {8'd0, io_pin_in});
      host_rev_ack = 1'b1;
      ok = 0;
      for (int i = 0; i < 30 && !ok; i++) begin
        @(negedge clk);
        ok = rev_clk_n;
      end
      check("R10 valid released after ack", {15'd0, ok}, 16'd1);
      io_pin_in = 8'($urandom);
      host_rev_ack = 1'b0;
    end
    repeat (2) @(negedge clk);
    host_rev_req = 1'b0;
    repeat (6) @(negedge clk);
    check("R11 lane released", {15'd0, bus_oe}, 16'd0);
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1284));
    repeat (3) @(negedge clk);
    check("R12 bus_oe", {15'd0, bus_oe}, 16'd0);
    check("R12 io_oe", {8'd0, io_oe}, 16'd0);
    check("R12 word", word_out, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 io_out", {8'd0, io_out}, 16'd0);
    check("R12 cs", {15'd0, word_cs}, 16'd0);

    // R13: data at channel 0 after reset goes nowhere
    send(1'b1, 8'hA5);
    check_outputs("R13 after reset");

    // R4/R5: low then high byte, one pulse of two clocks
    send(1'b0, {1'b1, A_WORD});
    send(1'b1, 8'h34);
    check("R5 no pulse after first byte", 16'(cs_pulses), 16'd0);
    send(1'b1, 8'h12);
    check("R4 word assembled", word_out, 16'h1234);
    check("R5 width", 16'(cs_last), 16'd2);
    check("R5 word under cs", cs_word, 16'h1234);

    // R6: address command restarts order
    send(1'b1, 8'h77);
    send(1'b0, {1'b1, A_WORD});
    send(1'b1, 8'h99);
    check("R6 restart low byte", word_out, 16'h1299);
    check_outputs("R6");

    // R2: run-length command ignored
    send(1'b0, 8'h05);
    send(1'b1, 8'hEE);
    check("R2 rle kept channel", word_out, 16'hEE99);
    check_outputs("R2");

    // R7/R8/R9/R10/R11 directed
    send(1'b0, {1'b1, A_DIR});
    send(1'b1, 8'hF0);
    send(1'b0, {1'b1, A_IO});
    send(1'b1, 8'h3C);
    check_outputs("R7 R8 directed");
    io_pin_in = 8'h5A;
    rev_read(3);

    // R11: no drive at a non-I/O channel
    send(1'b0, {1'b1, A_DIR});
    host_rev_req = 1'b1;
    repeat (12) @(negedge clk);
    check("R11 no drive off channel", {15'd0, bus_oe}, 16'd0);
    check("R11 no valid off channel", {15'd0, rev_clk_n}, 16'd1);
    host_rev_req = 1'b0;
    repeat (4) @(negedge clk);

    // Constrained random mix; R1 covered by command/data interleave
    for (int it = 0; it < 60; it++) begin
      int pick = $urandom_range(0, 9);
      logic [6:0] targets[4] = '{A_WORD, A_DIR, A_IO, 7'h05};
      if (pick < 3)      send(1'b0, {1'b1, targets[$urandom_range(0, 3)]});
      else if (pick < 4) send(1'b0, {1'b0, 7'($urandom)});
      else if (pick < 9) send(1'b1, 8'($urandom));
      else if (m_addr == A_IO) begin
        io_pin_in = 8'($urandom);
        rev_read(2);
      end
      check_outputs("R1 random");
    end

    finish_run();
  end
endmodule